// File: doc/BRIEF.md
# DAC Trigger and Data Controller

This block is the digital front-end of a single-channel 12-bit digital-to-analog converter. Software reaches it through a small register bus with five word addresses: a control word, a software strobe, the data word, a status word and a settling-delay word. The block decides when a conversion begins, extracts the 12-bit code from the data word, latches that code toward the analog core with a one-cycle load pulse, and then holds itself busy for a programmable settling time before it reports completion.

A conversion can start in two ways. With triggering off, a write to the data word starts it. With triggering on, it starts only on the selected event: a software strobe, an external pin (low level, high level, falling edge or rising edge, sampled through a synchronizer), one of four timer event pulses, or one of two PWM event pulses. A conversion started by a hardware source can raise a DMA request. The request stays up until the data word is written. If another hardware start arrives before that write, an under-run flag is set. The finish and under-run flags are cleared by writing 1 to them, and each can drive the interrupt output through its own enable bit. The output-buffer bypass bit is passed straight out to the analog side.

The sequencer has two states. IDLE moves to SETTLE on an accepted start, and the settle counter is loaded at that move. SETTLE stays in SETTLE while the counter is non-zero, decrementing it each cycle. SETTLE returns to IDLE when the counter reads zero, and that same edge sets the finish flag.

Top module: `dac_trig_ctrl`

## Requirements
- R1: After reset every register reads 0, and `dac_code`, `dac_load`, `conv_busy`, `irq`, `dma_req` and `buf_bypass` are all 0.
- R2: With control bit 5 (trigger enable) clear, a write to address 2 starts a conversion. `dac_load` pulses and `dac_code` updates in the cycle after the write edge. With trigger enable set, a write to address 2 starts nothing.
- R3: Control bit 3 picks the alignment. When it is 0, the code is data bits [11:0]. When it is 1, the code is data bits [15:4]. No other data bit reaches `dac_code`.
- R4: A conversion keeps `conv_busy`, which is also status bit 8, high for SETTLE+1 cycles, where SETTLE is the value at address 4. The edge that clears busy sets the finish flag, status bit 0.
- R5: With trigger enable set and source 0, writing 1 to bit 0 of address 1 starts a conversion. Address 1 always reads 0.
- R6: Source 1 uses the external pin after a two-flop synchronizer. Control bits [10:9] set the sense: 0 is low level, 1 is high level, 2 is falling edge and 3 is rising edge. An edge sense starts one conversion per edge. A level sense restarts a conversion after each one ends, for as long as the level holds.
- R7: Sources 2 to 5 select timer events 0 to 3, and sources 6 and 7 select PWM events 0 and 1. Events from sources that are not selected start nothing.
- R8: A trigger that arrives while busy is ignored: it neither starts a conversion nor changes `dac_code`.
- R9: A conversion started by a hardware source (source 1 to 7, trigger enable set) while control bit 2 (DMA enable) is set raises `dma_req`. The request stays high until a write to address 2.
- R10: A hardware start with DMA enabled while `dma_req` is still high, and no data write in the same cycle, sets the under-run flag, status bit 1.
- R11: Writing 1 to status bit 0 or bit 1 clears only that flag. Writing 0 leaves it unchanged.
- R12: `irq` is high when either the finish flag is set with control bit 0 set, or the under-run flag is set with control bit 1 set.
- R13: Control bit 4 appears unchanged on `buf_bypass`, and the control word reads back as it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| tmr_evt | input | 4 | Timer event pulses |
| pwm_evt | input | 2 | PWM event pulses |
| dac_code | output | 12 | Code latched for the analog core |
| dac_load | output | 1 | One-cycle pulse when a new code is latched |
| buf_bypass | output | 1 | Output-buffer bypass control |
| conv_busy | output | 1 | Conversion in progress |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request, cleared by a data write |

## Verification
The bench counts load pulses to tell edge sense from level sense. Holding the pin steady must give exactly one conversion for an edge and a continuing train for a level, so a design that confuses the two shows the wrong count. It sends a second timer pulse in the middle of a long settle, which catches a design that restarts or relatches the code while busy. It measures the busy window at SETTLE and SETTLE+1 cycles to expose a count that is off by one. It also fires a second hardware start before the data write, and writes 0 and the other flag's bit to the status word, to show that the under-run flag is set and that each flag clears only for its own bit.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_SETTLE} seq_state_t;

    typedef enum logic [2:0] {
        SRC_SOFT = 3'd0, SRC_PIN = 3'd1,
        SRC_TMR0 = 3'd2, SRC_TMR1 = 3'd3, SRC_TMR2 = 3'd4, SRC_TMR3 = 3'd5,
        SRC_PWM0 = 3'd6, SRC_PWM1 = 3'd7
    } trig_src_t;

    typedef enum logic [1:0] {SNS_LOW, SNS_HIGH, SNS_FALL, SNS_RISE} pin_sense_t;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_STRB   = 3'd1;
    localparam logic [2:0] A_DATA   = 3'd2;
    localparam logic [2:0] A_STAT   = 3'd3;
    localparam logic [2:0] A_SETTLE = 3'd4;

    localparam int CB_IE_DONE = 0;
    localparam int CB_IE_UDR  = 1;
    localparam int CB_DMA_EN  = 2;
    localparam int CB_LEFT    = 3;
    localparam int CB_BYPASS  = 4;
    localparam int CB_TRIG_EN = 5;
    localparam int CB_SRC_LSB = 6;
    localparam int CB_SNS_LSB = 9;
    localparam int CTRL_W     = 11;
    localparam int SB_BUSY    = 8;
endpackage

// File: rtl/dacc_pin_sync.sv
module dacc_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[SYNC_STAGES-1];
    end

    assign lvl  = chain_q[SYNC_STAGES-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/dacc_trig_sel.sv
module dacc_trig_sel
    import dacc_pkg::*;
#(
    parameter int N_TMR = 4,
    parameter int N_PWM = 2
) (
    input  trig_src_t        src,
    input  pin_sense_t       sense,
    input  logic             lvl,
    input  logic             rise,
    input  logic             fall,
    input  logic [N_TMR-1:0] tmr_evt,
    input  logic [N_PWM-1:0] pwm_evt,
    output logic             hw_evt
);
    localparam int TMR_BASE = 2;
    localparam int PWM_BASE = TMR_BASE + N_TMR;

    always_comb begin
        hw_evt = 1'b0;
        if (src == SRC_PIN) begin
            unique case (sense)
                SNS_LOW:  hw_evt = ~lvl;
                SNS_HIGH: hw_evt = lvl;
                SNS_FALL: hw_evt = fall;
                SNS_RISE: hw_evt = rise;
                default:  hw_evt = 1'b0;
            endcase
        end
        for (int i = 0; i < N_TMR; i++)
            if (int'(src) == TMR_BASE + i) hw_evt = tmr_evt[i];
        for (int i = 0; i < N_PWM; i++)
            if (int'(src) == PWM_BASE + i) hw_evt = pwm_evt[i];
    end
endmodule

// File: rtl/dacc_seq.sv
module dacc_seq
    import dacc_pkg::*;
#(
    parameter int DLY_W  = 8,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DLY_W-1:0]  delay,
    input  logic [CODE_W-1:0] code_in,
    output logic              busy,
    output logic              finish,
    output logic              load,
    output logic [CODE_W-1:0] code_out
);
    seq_state_t       state_q, state_d;
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)        state_d = ST_SETTLE;
            ST_SETTLE: if (cnt_q == '0)  state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            code_out <= '0;
            load     <= 1'b0;
        end else begin
            load <= 1'b0;
            if (state_q == ST_IDLE && start) begin
                cnt_q    <= delay;
                code_out <= code_in;
                load     <= 1'b1;
            end else if (state_q == ST_SETTLE && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy   = (state_q == ST_SETTLE);
    assign finish = (state_q == ST_SETTLE) && (cnt_q == '0);
endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
    import dacc_pkg::*;
#(
    parameter int BUS_W       = 32,
    parameter int CODE_W      = 12,
    parameter int DLY_W       = 8,
    parameter int N_TMR       = 4,
    parameter int N_PWM       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ext_pin,
    input  logic [N_TMR-1:0]  tmr_evt,
    input  logic [N_PWM-1:0]  pwm_evt,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_load,
    output logic              buf_bypass,
    output logic              conv_busy,
    output logic              irq,
    output logic              dma_req
);
    localparam int LEFT_LSB = 16 - CODE_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic [BUS_W-1:0]  dat_q, dat_view;
    logic [DLY_W-1:0]  settle_q;
    logic              done_q, udr_q, dma_q;
    logic              wr_ctrl, wr_strb, wr_dat, wr_stat, wr_settle;
    logic              lvl, rise, fall, hw_evt, sw_evt, trig_fire;
    logic              start, hw_start, finish, trig_en, dma_en;
    logic [CODE_W-1:0] code_sel;
    trig_src_t         src;
    pin_sense_t        sense;

    assign wr_ctrl   = bus_wr && bus_addr == A_CTRL;
    assign wr_strb   = bus_wr && bus_addr == A_STRB;
    assign wr_dat    = bus_wr && bus_addr == A_DATA;
    assign wr_stat   = bus_wr && bus_addr == A_STAT;
    assign wr_settle = bus_wr && bus_addr == A_SETTLE;

    assign trig_en = ctrl_q[CB_TRIG_EN];
    assign dma_en  = ctrl_q[CB_DMA_EN];
    assign src     = trig_src_t'(ctrl_q[CB_SRC_LSB +: 3]);
    assign sense   = pin_sense_t'(ctrl_q[CB_SNS_LSB +: 2]);

    dacc_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    dacc_trig_sel #(.N_TMR(N_TMR), .N_PWM(N_PWM)) u_sel (
        .src(src), .sense(sense), .lvl(lvl), .rise(rise), .fall(fall),
        .tmr_evt(tmr_evt), .pwm_evt(pwm_evt), .hw_evt(hw_evt)
    );

    assign sw_evt    = wr_strb && bus_wdata[0];
    assign trig_fire = trig_en ? ((src == SRC_SOFT) ? sw_evt : hw_evt) : wr_dat;
    assign start     = trig_fire && !conv_busy;
    assign hw_start  = start && trig_en && (src != SRC_SOFT);

    assign dat_view = wr_dat ? bus_wdata : dat_q;
    assign code_sel = ctrl_q[CB_LEFT] ? dat_view[LEFT_LSB +: CODE_W]
                                      : dat_view[CODE_W-1:0];

    dacc_seq #(.DLY_W(DLY_W), .CODE_W(CODE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .delay(settle_q),
        .code_in(code_sel), .busy(conv_busy), .finish(finish),
        .load(dac_load), .code_out(dac_code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            dat_q    <= '0;
            settle_q <= '0;
        end else begin
            if (wr_ctrl)   ctrl_q   <= bus_wdata[CTRL_W-1:0];
            if (wr_dat)    dat_q    <= bus_wdata;
            if (wr_settle) settle_q <= bus_wdata[DLY_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            udr_q  <= 1'b0;
            dma_q  <= 1'b0;
        end else begin
            if (finish)                     done_q <= 1'b1;
            else if (wr_stat && bus_wdata[0]) done_q <= 1'b0;

            if (hw_start && dma_en && dma_q && !wr_dat) udr_q <= 1'b1;
            else if (wr_stat && bus_wdata[1])           udr_q <= 1'b0;

            if (hw_start && dma_en) dma_q <= 1'b1;
            else if (wr_dat)        dma_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:   bus_rdata[CTRL_W-1:0] = ctrl_q;
            A_DATA:   bus_rdata = dat_q;
            A_STAT: begin
                bus_rdata[0]       = done_q;
                bus_rdata[1]       = udr_q;
                bus_rdata[SB_BUSY] = conv_busy;
            end
            A_SETTLE: bus_rdata[DLY_W-1:0] = settle_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq        = (done_q && ctrl_q[CB_IE_DONE]) || (udr_q && ctrl_q[CB_IE_UDR]);
    assign dma_req    = dma_q;
    assign buf_bypass = ctrl_q[CB_BYPASS];
endmodule

// File: rtl/dac_trig_ctrl_chk.sv
module dac_trig_ctrl_chk #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              conv_busy,
    input logic              done_q,
    input logic              udr_q,
    input logic [CODE_W-1:0] dac_code,
    input logic              dac_load,
    input logic              dma_req,
    input logic              dma_en,
    input logic              irq
);
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> conv_busy);

    p_finish_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_busy) |-> done_q);

    p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && $past(conv_busy)) |-> $stable(dac_code));

    p_load_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> conv_busy);

    p_dma_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(dma_en));

    p_udr_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udr_q) |-> $past(dma_req));

    p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_q || udr_q));
endmodule

bind dac_trig_ctrl dac_trig_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .conv_busy(conv_busy),
    .done_q(done_q), .udr_q(udr_q), .dac_code(dac_code), .dac_load(dac_load),
    .dma_req(dma_req), .dma_en(dma_en), .irq(irq)
);

// File: tb/tb_dac_trig_ctrl.sv
`timescale 1ns/1ps
module tb_dac_trig_ctrl;
    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, ext_pin = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [3:0]  tmr_evt = '0;
    logic [1:0]  pwm_evt = '0;
    logic [11:0] dac_code;
    logic        dac_load, buf_bypass, conv_busy, irq, dma_req;
    int total = 0, bad = 0, nload = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dac_trig_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
        .tmr_evt(tmr_evt), .pwm_evt(pwm_evt), .dac_code(dac_code),
        .dac_load(dac_load), .buf_bypass(buf_bypass), .conv_busy(conv_busy),
        .irq(irq), .dma_req(dma_req)
    );

    always @(posedge clk) if (dac_load) nload++;

    // {left, data word, expected code}
    localparam logic [44:0] VEC [6] = '{
        {1'b0, 32'h0000_0ABC, 12'hABC},
        {1'b0, 32'hFFFF_F123, 12'h123},
        {1'b0, 32'h0000_0FFF, 12'hFFF},
        {1'b1, 32'h0000_ABC0, 12'hABC},
        {1'b1, 32'hFFFF_1237, 12'h123},
        {1'b1, 32'h0000_000F, 12'h000}
    };

    function automatic logic [31:0] mk(input bit ten, input int src, input int sns,
                                       input bit left, input bit dma, input bit ied,
                                       input bit ieu, input bit byp);
        return 32'((ied ? 1 : 0) | (ieu ? 2 : 0) | (dma ? 4 : 0) | (left ? 8 : 0) |
                   (byp ? 16 : 0) | (ten ? 32 : 0) | (src << 6) | (sns << 9));
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tpulse(input int i);
        tmr_evt[i] = 1'b1; @(negedge clk); tmr_evt = '0;
    endtask

    initial begin
        logic [31:0] r;
        int n0;
        cyc(3); rst_n = 1'b1; cyc(1);

        // R1 reset state
        rd(3'd0, r); chk("R1 ctrl", r, 0);
        rd(3'd3, r); chk("R1 stat", r, 0);
        chk("R1 outs", {dac_code, dac_load, conv_busy, irq, dma_req, buf_bypass}, 0);
        cyc(1);

        // R2/R3 vector walk
        foreach (VEC[i]) begin
            wr(3'd0, mk(0, 0, 0, VEC[i][44], 0, 0, 0, 0));
            wr(3'd2, VEC[i][43:12]);
            chk("R2 load", dac_load, 1);
            chk("R3 code", dac_code, VEC[i][11:0]);
            cyc(2);
        end

        // R4 settle window and finish
        wr(3'd0, 0); wr(3'd4, 5); wr(3'd2, 32'h55);
        rd(3'd3, r); chk("R4 busy bit", r[8], 1);
        cyc(5); chk("R4 busy at SETTLE", conv_busy, 1);
        cyc(1); chk("R4 idle after SETTLE+1", conv_busy, 0);
        rd(3'd3, r); chk("R4 finish", r, 1);
        chk("R12 irq masked", irq, 0);
        cyc(1);
        wr(3'd0, mk(0, 0, 0, 0, 0, 1, 0, 0));
        chk("R12 irq finish", irq, 1);
        // R11 write-one-to-clear
        wr(3'd3, 32'h2); rd(3'd3, r); chk("R11 other bit kept", r, 1); cyc(1);
        wr(3'd3, 32'h0); rd(3'd3, r); chk("R11 zero kept", r, 1); cyc(1);
        wr(3'd3, 32'h1); rd(3'd3, r); chk("R11 cleared", r, 0);
        chk("R12 irq low", irq, 0); cyc(1);

        // R2 data write does not start when triggering is on
        wr(3'd4, 20);
        wr(3'd0, mk(1, 2, 0, 0, 0, 0, 0, 0));
        n0 = nload; wr(3'd2, 32'h777); cyc(2);
        chk("R2 no start", {31'd0, conv_busy}, 0);
        chk("R2 no load", nload - n0, 0);

        // R7 wrong source ignored, then timer 0
        tpulse(1); chk("R7 unselected timer", conv_busy, 0);
        pwm_evt = 2'b11; cyc(1); pwm_evt = '0;
        chk("R7 unselected pwm", conv_busy, 0);
        n0 = nload; tpulse(0); chk("R7 timer0", conv_busy, 1);
        chk("R7 code", dac_code, 12'h777);
        cyc(5); wr(3'd2, 32'h111); tpulse(0);
        cyc(20);
        chk("R8 ignored while busy", nload - n0, 1);
        chk("R8 code held", dac_code, 12'h777);
        cyc(1);
        wr(3'd4, 2); wr(3'd0, mk(1, 7, 0, 0, 0, 0, 0, 0));
        pwm_evt[1] = 1'b1; cyc(1); pwm_evt = '0;
        chk("R7 pwm1", conv_busy, 1); cyc(4);

        // R5 software strobe
        wr(3'd0, mk(1, 0, 0, 0, 0, 0, 0, 0));
        wr(3'd1, 1); chk("R5 strobe start", conv_busy, 1);
        rd(3'd1, r); chk("R5 strobe reads 0", r, 0); cyc(5);

        // R6 pin senses
        wr(3'd0, mk(1, 1, 3, 0, 0, 0, 0, 0));
        n0 = nload; ext_pin = 1'b1; cyc(15);
        chk("R6 rising one shot", nload - n0, 1);
        wr(3'd0, mk(1, 1, 2, 0, 0, 0, 0, 0));
        n0 = nload; ext_pin = 1'b0; cyc(15);
        chk("R6 falling one shot", nload - n0, 1);
        wr(3'd0, mk(1, 1, 1, 0, 0, 0, 0, 0));
        n0 = nload; cyc(8); chk("R6 high level idle", nload - n0, 0);
        ext_pin = 1'b1; cyc(20);
        chk("R6 high level repeats", 32'(nload - n0 >= 2), 1);
        ext_pin = 1'b0; cyc(8);
        wr(3'd0, mk(1, 1, 0, 0, 0, 0, 0, 0));
        n0 = nload; cyc(20);
        chk("R6 low level repeats", 32'(nload - n0 >= 2), 1);
        wr(3'd0, 0); cyc(6);

        // R9/R10 DMA and under-run
        wr(3'd4, 1);
        wr(3'd0, mk(1, 3, 0, 0, 0, 0, 1, 0));
        tpulse(1); chk("R9 no dma when disabled", dma_req, 0); cyc(3);
        wr(3'd0, mk(1, 3, 0, 0, 1, 0, 1, 0));
        tpulse(1); chk("R9 dma raised", dma_req, 1); cyc(3);
        chk("R9 dma held", dma_req, 1);
        tpulse(1); rd(3'd3, r); chk("R10 underrun", r[1], 1);
        chk("R12 irq underrun", irq, 1); cyc(3);
        wr(3'd2, 32'h0); chk("R9 dma cleared", dma_req, 0);
        chk("R2 trig on data write", conv_busy, 0);
        wr(3'd3, 32'h2); rd(3'd3, r); chk("R11 underrun cleared", r[1], 0); cyc(1);

        // R13 bypass pass-through
        wr(3'd0, mk(0, 0, 0, 0, 0, 0, 0, 1));
        chk("R13 bypass", buf_bypass, 1);
        rd(3'd0, r); chk("R13 readback", r, 32'h10);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule